// File: doc/BRIEF.md
# TDM Network-Mode Serial Transmitter

This block turns a stream of audio words into one serial data line carrying a time-division-multiplexed frame. A frame holds a configurable number of slots, each a configurable number of bit periods long. Every enabled slot carries one word, sent most significant bit first, placed at the start of the slot, with the rest of the slot filled. A frame-sync output marks slot 0. It is either one bit period wide or as wide as the whole first slot. It can also lead the first data bit by one bit period.

The transmitter does not make its own bit clock. A clock divider supplies two single-cycle strobes, one for each edge of the bit clock. The selected bit-clock polarity decides which strobe launches data, so the receiver can sample on the other edge. Words come from a ready/valid source: the block raises `in_ready` for one cycle at the start of each enabled slot. A per-slot mask chooses which slots carry data. A masked slot takes no word and leaves the line quiet. If no word is available for an enabled slot, that slot carries zeros and a sticky underrun flag is raised.

Three format presets set the polarities and the frame-sync shape: plain, I2S-style and DSP-A-style. Two inversion bits flip the bit-clock polarity and the frame-sync polarity on top of any preset. The configuration is meant to be changed only while `en` is low.

Top module: `tdm_net_tx`

## Requirements
- R1: While `en` is low, `sd_out` and `sd_oe` are 0 from the next cycle on, `in_ready` is 0, and `fs_out` sits at its inactive level.
- R2: With padding on, an enabled slot sends the low W bits of `in_data` MSB first, followed by zeros up to the slot length. W is set by `cfg_wlen`: 0→8, 1→12, 2→16, 3→20, 4 to 7→24. Bits of `in_data` above W have no effect on the line.
- R3: With `cfg_pad_en`=0, the slot bits after the word's LSB repeat that LSB.
- R4: A frame is `cfg_slots` slots of `cfg_slot_len` bit periods each. Frames follow one another without gaps, starting at slot 0 on the first data bit after `en` rises.
- R5: The frame sync is active for bit 0 of slot 0 only when `cfg_fs_bit`=1 or the format is DSP-A. Otherwise it is active for every bit of slot 0.
- R6: With `cfg_fs_early`=1, the frame-sync pattern moves one bit period earlier. The first launch after `en` rises is then a lead-in period, with the frame sync active and `sd_oe`=0, and the first data bit follows it.
- R7: A slot whose `cfg_mask` bit is 0 sends `sd_out`=0 with `sd_oe`=0 and takes no word. `sd_oe` is 1 for every bit of an enabled slot.
- R8: `in_ready` is high for exactly one cycle, the launching strobe cycle, at the start of each enabled slot. A word is taken when `in_valid` is high in that cycle.
- R9: An enabled slot that starts with `in_valid` low sends all zeros and sets `urun`. `urun` then stays 1 until `urun_clr` is pulsed.
- R10: `cfg_fmt` sets the polarities: 0=plain (frame sync active high, launch on `fall_tick`), 1=I2S (frame sync active low, launch on `rise_tick`), 2=DSP-A (frame sync active high, launch on `rise_tick`), 3=plain. `cfg_inv_bclk` swaps the launching strobe and `cfg_inv_fs` inverts `fs_out`.
- R11: `sd_out`, `sd_oe` and `fs_out` change only on the clock edge that ends a launching-strobe cycle. The other strobe leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low returns the block to idle |
| rise_tick | input | 1 | Strobe marking a rising bit-clock edge |
| fall_tick | input | 1 | Strobe marking a falling bit-clock edge |
| cfg_fmt | input | 2 | Format preset (0 plain, 1 I2S, 2 DSP-A) |
| cfg_inv_bclk | input | 1 | Swap the launching strobe |
| cfg_inv_fs | input | 1 | Invert frame-sync polarity |
| cfg_fs_bit | input | 1 | One-bit frame sync instead of slot-long |
| cfg_fs_early | input | 1 | Frame sync leads data by one bit period |
| cfg_pad_en | input | 1 | Zero fill after the word (else repeat LSB) |
| cfg_wlen | input | 3 | Word width code |
| cfg_slots | input | CNT_W (4) | Slots per frame |
| cfg_slot_len | input | BIT_W (6) | Bit periods per slot |
| cfg_mask | input | MAX_SLOTS (8) | Per-slot enable, bit n for slot n |
| in_valid | input | 1 | A word is offered |
| in_data | input | 24 | Word, right-justified |
| in_ready | output | 1 | Word taken this cycle when valid |
| urun_clr | input | 1 | Clears the underrun flag |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Data line is driven by an enabled slot |
| fs_out | output | 1 | Frame sync |
| urun | output | 1 | Sticky underrun flag |

## Verification
The bench goes after the frame-sync edges. An early sync that is placed off by one would show up on the last bit of the final slot and on the lead-in period. A slot-long sync that ends too soon or runs too long would show up on bit 0 of slot 1. It also checks the fill bits after words narrower than the slot: a wrong left shift would move data into the fill, and a wrong fill mode would give zeros where the LSB should repeat. Masked slots and the all-masked frame catch a design that takes words or drives `sd_oe` in an empty slot, which would throw the word order off by one. Each bit is sampled after both strobes, so launching on the wrong edge shows up as a value one strobe early.

// File: rtl/tdm_tx_pkg.sv
`timescale 1ns/1ps
package tdm_tx_pkg;

    localparam int unsigned WORD_MAX = 24;

    typedef enum logic [1:0] {
        FMT_PLAIN = 2'd0,
        FMT_I2S   = 2'd1,
        FMT_DSPA  = 2'd2,
        FMT_RSVD  = 2'd3
    } fmt_e;

    // word width in bits for a width code; codes past 4 select the widest
    function automatic logic [4:0] word_bits(input logic [2:0] code);
        case (code)
            3'd0:    return 5'd8;
            3'd1:    return 5'd12;
            3'd2:    return 5'd16;
            3'd3:    return 5'd20;
            default: return 5'd24;
        endcase
    endfunction

endpackage

// File: rtl/tdm_tx_frame_seq.sv
`timescale 1ns/1ps
module tdm_tx_frame_seq #(
    parameter int MAX_SLOTS = 8,
    parameter int SLOT_MAX  = 32,
    localparam int CNT_W   = $clog2(MAX_SLOTS + 1),
    localparam int SLOT_IW = $clog2(MAX_SLOTS),
    localparam int BIT_W   = $clog2(SLOT_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               tick,
    input  logic               fs_early,
    input  logic               fs_word,
    input  logic [CNT_W-1:0]   slots,
    input  logic [BIT_W-1:0]   slot_len,
    output logic               step,
    output logic               lead,
    output logic               slot_start,
    output logic [SLOT_IW-1:0] cur_slot,
    output logic [BIT_W-1:0]   cur_bit,
    output logic               fs_now
);

    typedef struct packed {
        logic [SLOT_IW-1:0] slot;
        logic [BIT_W-1:0]   bitn;
        logic               primed;
    } seq_t;

    seq_t seq_q, seq_d;

    logic               run_c;
    logic               last_bit_c;
    logic               last_slot_c;
    logic [BIT_W-1:0]   nbit_c;
    logic [SLOT_IW-1:0] nslot_c;
    logic               cur_fs_c;
    logic               nxt_fs_c;

    always_comb begin
        run_c       = en && (seq_q.primed || !fs_early);
        step        = tick && run_c;
        lead        = tick && en && !run_c;
        last_bit_c  = (seq_q.bitn == slot_len - 1'b1);
        last_slot_c = (seq_q.slot == SLOT_IW'(slots - 1'b1));
        nbit_c      = last_bit_c ? '0 : seq_q.bitn + 1'b1;
        nslot_c     = last_bit_c ? (last_slot_c ? '0 : seq_q.slot + 1'b1) : seq_q.slot;
        cur_fs_c    = (seq_q.slot == '0) && (fs_word || (seq_q.bitn == '0));
        nxt_fs_c    = (nslot_c == '0) && (fs_word || (nbit_c == '0));
        fs_now      = lead ? 1'b1 : (fs_early ? nxt_fs_c : cur_fs_c);
        slot_start  = step && (seq_q.bitn == '0);
        cur_slot    = seq_q.slot;
        cur_bit     = seq_q.bitn;

        seq_d = seq_q;
        if (!en) begin
            seq_d = '0;
        end else if (lead) begin
            seq_d.primed = 1'b1;
        end else if (step) begin
            seq_d.slot = nslot_c;
            seq_d.bitn = nbit_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

endmodule

// File: rtl/tdm_tx_lane.sv
`timescale 1ns/1ps
module tdm_tx_lane
    import tdm_tx_pkg::*;
#(
    parameter int BIT_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                step,
    input  logic                lead,
    input  logic                slot_start,
    input  logic                slot_on,
    input  logic [BIT_W-1:0]    cur_bit,
    input  logic [4:0]          wbits,
    input  logic                pad_en,
    input  logic                fs_now,
    input  logic                fs_low,
    input  logic                in_valid,
    input  logic [WORD_MAX-1:0] in_data,
    input  logic                urun_clr,
    output logic                in_ready,
    output logic                sd_out,
    output logic                sd_oe,
    output logic                fs_out,
    output logic                urun
);

    typedef struct packed {
        logic [WORD_MAX-1:0] word;
        logic                sd;
        logic                oe;
        logic                fs;
        logic                urun;
    } lane_t;

    lane_t lane_q, lane_d;

    logic                take_c;
    logic [WORD_MAX-1:0] loaded_c;
    logic [WORD_MAX-1:0] cur_c;
    logic [BIT_W-1:0]    wlim_c;

    always_comb begin
        in_ready = slot_start && slot_on;
        take_c   = in_ready && in_valid;
        loaded_c = take_c ? (in_data << (5'(WORD_MAX) - wbits)) : '0;
        cur_c    = slot_start ? loaded_c : lane_q.word;
        wlim_c   = BIT_W'(wbits);

        lane_d = lane_q;
        if (!en) begin
            lane_d.word = '0;
            lane_d.sd   = 1'b0;
            lane_d.oe   = 1'b0;
            lane_d.fs   = fs_low;
        end else if (lead) begin
            lane_d.sd = 1'b0;
            lane_d.oe = 1'b0;
            lane_d.fs = fs_now ^ fs_low;
        end else if (step) begin
            lane_d.word = cur_c << 1;
            lane_d.oe   = slot_on;
            if (!slot_on)             lane_d.sd = 1'b0;
            else if (cur_bit < wlim_c) lane_d.sd = cur_c[WORD_MAX-1];
            else                      lane_d.sd = pad_en ? 1'b0 : lane_q.sd;
            lane_d.fs   = fs_now ^ fs_low;
        end

        if (in_ready && !in_valid) lane_d.urun = 1'b1;
        else if (urun_clr)         lane_d.urun = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign sd_out = lane_q.sd;
    assign sd_oe  = lane_q.oe;
    assign fs_out = lane_q.fs;
    assign urun   = lane_q.urun;

endmodule

// File: rtl/tdm_net_tx.sv
`timescale 1ns/1ps
module tdm_net_tx
    import tdm_tx_pkg::*;
#(
    parameter int MAX_SLOTS = 8,
    parameter int SLOT_MAX  = 32,
    localparam int CNT_W   = $clog2(MAX_SLOTS + 1),
    localparam int SLOT_IW = $clog2(MAX_SLOTS),
    localparam int BIT_W   = $clog2(SLOT_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 rise_tick,
    input  logic                 fall_tick,
    input  logic [1:0]           cfg_fmt,
    input  logic                 cfg_inv_bclk,
    input  logic                 cfg_inv_fs,
    input  logic                 cfg_fs_bit,
    input  logic                 cfg_fs_early,
    input  logic                 cfg_pad_en,
    input  logic [2:0]           cfg_wlen,
    input  logic [CNT_W-1:0]     cfg_slots,
    input  logic [BIT_W-1:0]     cfg_slot_len,
    input  logic [MAX_SLOTS-1:0] cfg_mask,
    input  logic                 in_valid,
    input  logic [WORD_MAX-1:0]  in_data,
    output logic                 in_ready,
    input  logic                 urun_clr,
    output logic                 sd_out,
    output logic                 sd_oe,
    output logic                 fs_out,
    output logic                 urun
);

    fmt_e               fmt_c;
    logic               bclk_low_c;
    logic               fs_low_c;
    logic               tick_c;
    logic               fs_word_c;
    logic               slot_on_c;
    logic [4:0]         wbits_c;

    logic               step_w;
    logic               lead_w;
    logic               slot_start_w;
    logic [SLOT_IW-1:0] cur_slot_w;
    logic [BIT_W-1:0]   cur_bit_w;
    logic               fs_now_w;

    always_comb begin
        fmt_c      = fmt_e'(cfg_fmt);
        bclk_low_c = ((fmt_c == FMT_I2S) || (fmt_c == FMT_DSPA)) ^ cfg_inv_bclk;
        fs_low_c   = (fmt_c == FMT_I2S) ^ cfg_inv_fs;
        tick_c     = bclk_low_c ? rise_tick : fall_tick;
        fs_word_c  = !cfg_fs_bit && (fmt_c != FMT_DSPA);
        slot_on_c  = cfg_mask[cur_slot_w];
        wbits_c    = word_bits(cfg_wlen);
    end

    tdm_tx_frame_seq #(
        .MAX_SLOTS (MAX_SLOTS),
        .SLOT_MAX  (SLOT_MAX)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .tick       (tick_c),
        .fs_early   (cfg_fs_early),
        .fs_word    (fs_word_c),
        .slots      (cfg_slots),
        .slot_len   (cfg_slot_len),
        .step       (step_w),
        .lead       (lead_w),
        .slot_start (slot_start_w),
        .cur_slot   (cur_slot_w),
        .cur_bit    (cur_bit_w),
        .fs_now     (fs_now_w)
    );

    tdm_tx_lane #(
        .BIT_W (BIT_W)
    ) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .step       (step_w),
        .lead       (lead_w),
        .slot_start (slot_start_w),
        .slot_on    (slot_on_c),
        .cur_bit    (cur_bit_w),
        .wbits      (wbits_c),
        .pad_en     (cfg_pad_en),
        .fs_now     (fs_now_w),
        .fs_low     (fs_low_c),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .urun_clr   (urun_clr),
        .in_ready   (in_ready),
        .sd_out     (sd_out),
        .sd_oe      (sd_oe),
        .fs_out     (fs_out),
        .urun       (urun)
    );

endmodule

// File: rtl/tdm_net_tx_chk.sv
`timescale 1ns/1ps
module tdm_net_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic rise_tick,
    input logic fall_tick,
    input logic in_valid,
    input logic in_ready,
    input logic urun_clr,
    input logic sd_out,
    input logic sd_oe,
    input logic fs_out,
    input logic urun
);

    // R1
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sd_out && !sd_oe));

    // R1
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !in_ready);

    // R7
    quiet_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_oe |-> !sd_out);

    // R8
    ready_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (rise_tick || fall_tick));

    // R11
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !rise_tick && !fall_tick) |=> ($stable(sd_out) && $stable(sd_oe) && $stable(fs_out)));

    // R9
    urun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> urun);

    // R9
    urun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (urun && !urun_clr) |=> urun);

endmodule

bind tdm_net_tx tdm_net_tx_chk u_chk (.*);

// File: tb/tb_tdm_net_tx.sv
`timescale 1ns/1ps
module tb_tdm_net_tx;

    localparam int MAX_SLOTS = 8;
    localparam int SLOT_MAX  = 32;
    localparam int CNT_W     = $clog2(MAX_SLOTS + 1);
    localparam int BIT_W     = $clog2(SLOT_MAX + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 en = 1'b0;
    logic                 rise_tick = 1'b0;
    logic                 fall_tick = 1'b0;
    logic [1:0]           cfg_fmt = '0;
    logic                 cfg_inv_bclk = 1'b0;
    logic                 cfg_inv_fs = 1'b0;
    logic                 cfg_fs_bit = 1'b0;
    logic                 cfg_fs_early = 1'b0;
    logic                 cfg_pad_en = 1'b1;
    logic [2:0]           cfg_wlen = '0;
    logic [CNT_W-1:0]     cfg_slots = 4'd2;
    logic [BIT_W-1:0]     cfg_slot_len = 6'd8;
    logic [MAX_SLOTS-1:0] cfg_mask = '0;
    logic                 in_valid = 1'b0;
    logic [23:0]          in_data = '0;
    logic                 in_ready;
    logic                 urun_clr = 1'b0;
    logic                 sd_out, sd_oe, fs_out, urun;

    always #2.5 clk = ~clk;

    tdm_net_tx #(.MAX_SLOTS(MAX_SLOTS), .SLOT_MAX(SLOT_MAX)) dut (.*);

    typedef struct packed {
        logic [1:0] fmt;
        logic       inv_b;
        logic       inv_f;
        logic       fs_bit;
        logic       early;
        logic       pad;
        logic [2:0] wlen;
        logic [3:0] slots;
        logic [5:0] slen;
        logic [7:0] mask;
        logic [7:0] seed;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 4'd2, 6'd16, 8'h03, 8'h11},
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4, 4'd2, 6'd32, 8'h03, 8'h22},
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 4'd4, 6'd8,  8'h0B, 8'h33},
        '{2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 4'd3, 6'd16, 8'h07, 8'h44},
        '{2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd3, 4'd1, 6'd24, 8'h01, 8'h55},
        '{2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'd0, 4'd8, 6'd8,  8'h5A, 8'h66},
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 4'd4, 6'd20, 8'h06, 8'h77},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd5, 4'd2, 6'd24, 8'h01, 8'h88},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 4'd2, 6'd8,  8'h00, 8'h99}
    };

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    int         rdy_seen;
    int         k_drv;
    int         starve_lim;
    logic [7:0] cur_seed;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [23:0] wgen(input int k, input logic [7:0] seed);
        logic [31:0] p;
        p = (k + 1) * 32'h0006D2B7;
        return p[23:0] ^ {seed, ~seed, seed};
    endfunction

    function automatic int wbits_tb(input logic [2:0] c);
        case (c)
            3'd0: return 8;
            3'd1: return 12;
            3'd2: return 16;
            3'd3: return 20;
            default: return 24;
        endcase
    endfunction

    function automatic bit in_fs(input int s, input int b, input bit word);
        return (s == 0) && (word || b == 0);
    endfunction

    // one strobe cycle starting and ending at a falling clock edge
    task automatic tick_once(input bit r);
        bit hs;
        rise_tick = r;
        fall_tick = !r;
        #1;
        hs = in_ready && in_valid;
        if (in_ready) rdy_seen++;
        @(posedge clk);
        @(negedge clk);
        rise_tick = 1'b0;
        fall_tick = 1'b0;
        if (hs) begin
            k_drv++;
            in_data = wgen(k_drv, cur_seed);
        end
        in_valid = (rdy_seen >= starve_lim);
    endtask

    task automatic do_bit(input bit bl, input logic [2:0] exp, input string req);
        logic [2:0] prev, s1, s2, e1;
        prev = {sd_out, sd_oe, fs_out};
        tick_once(1'b1);
        s1 = {sd_out, sd_oe, fs_out};
        tick_once(1'b0);
        s2 = {sd_out, sd_oe, fs_out};
        e1 = bl ? exp : prev;
        check((s1 == e1) && (s2 == exp), req, {26'd0, s1, s2}, {26'd0, e1, exp});
    endtask

    task automatic run_vec(input vec_t v, input int starve_n, input int frames);
        int    w;
        bit    bl, fl, fw;
        int    k_model, e_idx, exp_rdy;
        logic [23:0] cur_w;
        string tag;
        w  = wbits_tb(v.wlen);
        bl = ((v.fmt == 2'd1) || (v.fmt == 2'd2)) ^ v.inv_b;
        fl = (v.fmt == 2'd1) ^ v.inv_f;
        fw = !v.fs_bit && (v.fmt != 2'd2);
        k_model = 0;
        e_idx   = 0;
        exp_rdy = 0;
        tag = $sformatf("R2 R4 R5 R10 R11 %s%s R7 vec_seed=%h", v.pad ? "" : "R3", v.early ? " R6" : "", v.seed);

        en = 1'b0;
        cfg_fmt = v.fmt; cfg_inv_bclk = v.inv_b; cfg_inv_fs = v.inv_f;
        cfg_fs_bit = v.fs_bit; cfg_fs_early = v.early; cfg_pad_en = v.pad;
        cfg_wlen = v.wlen; cfg_slots = v.slots; cfg_slot_len = v.slen; cfg_mask = v.mask;
        urun_clr = 1'b1;
        @(negedge clk);
        urun_clr = 1'b0;
        @(negedge clk);
        // R1: idle line with this configuration's polarity
        check({sd_out, sd_oe, fs_out, in_ready} == {1'b0, 1'b0, fl, 1'b0}, "R1 idle",
              {28'd0, sd_out, sd_oe, fs_out, in_ready}, {28'd0, 1'b0, 1'b0, fl, 1'b0});

        cur_seed   = v.seed;
        starve_lim = starve_n;
        rdy_seen   = 0;
        k_drv      = 0;
        in_data    = wgen(0, v.seed);
        in_valid   = (starve_n == 0);
        en = 1'b1;

        if (v.early) do_bit(bl, {1'b0, 1'b0, 1'b1 ^ fl}, "R6 lead-in");

        for (int f = 0; f < frames; f++) begin
            for (int s = 0; s < int'(v.slots); s++) begin
                bit on;
                on = v.mask[s];
                cur_w = '0;
                if (on) begin
                    exp_rdy++;
                    if (e_idx >= starve_n) begin
                        cur_w = wgen(k_model, v.seed);
                        k_model++;
                    end
                    e_idx++;
                end
                for (int b = 0; b < int'(v.slen); b++) begin
                    int   ns, nb;
                    logic d;
                    bit   fa;
                    nb = (b == int'(v.slen) - 1) ? 0 : b + 1;
                    ns = (b == int'(v.slen) - 1) ? ((s == int'(v.slots) - 1) ? 0 : s + 1) : s;
                    if (!on)       d = 1'b0;
                    else if (b < w) d = cur_w[w - 1 - b];
                    else           d = v.pad ? 1'b0 : cur_w[0];
                    fa = v.early ? in_fs(ns, nb, fw) : in_fs(s, b, fw);
                    do_bit(bl, {d, on, fa ^ fl}, tag);
                end
            end
        end

        // R8 and R7: one ready pulse per enabled slot, none for masked slots
        check(rdy_seen == exp_rdy, "R8 R7 ready count", rdy_seen, exp_rdy);
        // R9: flag reflects whether any enabled slot was starved
        check(urun == (starve_n > 0), "R9 underrun flag", {31'd0, urun}, {31'd0, starve_n > 0});

        en = 1'b0;
        @(negedge clk);
        // R1: disabling mid-stream returns the line to idle on the next cycle
        check({sd_out, sd_oe, fs_out, in_ready} == {1'b0, 1'b0, fl, 1'b0}, "R1 disable",
              {28'd0, sd_out, sd_oe, fs_out, in_ready}, {28'd0, 1'b0, 1'b0, fl, 1'b0});
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        vec_t uv;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({sd_out, sd_oe, in_ready, urun} == 4'b0, "R1 reset",
              {28'd0, sd_out, sd_oe, in_ready, urun}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i], 0, 2);

        // R9: first enabled slot starved, zeros sent, flag sticks after data resumes
        uv = '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 4'd2, 6'd8, 8'h03, 8'hC3};
        run_vec(uv, 1, 2);
        @(negedge clk);
        check(urun == 1'b1, "R9 sticky while idle", {31'd0, urun}, 32'd1);
        urun_clr = 1'b1;
        @(negedge clk);
        urun_clr = 1'b0;
        check(urun == 1'b0, "R9 cleared", {31'd0, urun}, 32'd0);

        // R9: two starved slots, underrun across a frame boundary
        uv = '{2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 4'd3, 6'd12, 8'h05, 8'h5C};
        run_vec(uv, 2, 2);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule